// File: doc/BRIEF.md
# Two-Class Virtual Channel Scheduler

This block chooses which of `N` virtual channels may use a shared router resource next. That resource can be a crossbar input or an outgoing link. The lowest `K` channel indices are kept for guaranteed-throughput (GT) packets. The channels from `K` to `N-1` carry best-effort (BE) packets. A GT packet may also travel on a BE channel. A BE packet is never accepted on a GT channel.

Each channel presents four things:
- a request;
- a class bit, which is read only when that channel's head flit is a header;
- a 2-bit flit type;
- a shared stall flag for the packet currently granted.

The scheduler's outputs are a one-hot grant, the granted index and a valid flag. All three are combinational from the present inputs and the registered scheduler state. A flit moves in any cycle in which the granted channel requests and the stall flag is low.

Once a header flit has moved, the grant stays on that channel until the packet ends. A packet ends on a tail flit or after `PKT_LEN` flits, whichever comes first. A stall also releases the grant, and the scheduler re-arbitrates in the next cycle. GT-class requests always win over BE-class requests. Each class has its own round-robin pointer, which moves only when a packet completes.

Top module: `gtbe_vc_sched`

## Requirements
- R1: After reset, no channel is locked and both round-robin pointers are 0. With no requests, the grant is all zeros and the valid flag is low.
- R2: The grant has at most one bit set. When the valid flag is high, the bit at the reported index is set.
- R3: When the scheduler is free to arbitrate and any GT-class request is pending, the grant goes to a GT-class request, even if BE-class requests are also pending.
- R4: BE-class requests are served in round-robin order. After a BE packet completes on channel g, the BE search starts at g+1, wrapping to 0 after N-1.
- R5: GT-class requests are served in round-robin order. The GT pointer behaves like the BE pointer but is a separate register.
- R6: A request on a channel with index below K is ignored if its header carries the BE class bit (0). It is never granted.
- R7: A header with class bit 1 on a channel with index K or above is a spilled GT packet. It competes in the GT class.
- R8: After a header flit moves, the grant stays on that channel for every following cycle until the packet ends or a stall occurs. This holds even when higher-class requests arrive.
- R9: A stall (blocked_i high while a grant is valid) moves no flit and releases the grant, so arbitration runs again in the next cycle. The stalled channel keeps its flit count. It also keeps the class latched from its header, and it resumes mid-packet when it is granted again.
- R10: Flit type codes are: 2'b01 header, 2'b00 data, 2'b10 tail and 2'b11 data. A tail flit that moves ends the packet, even if the packet is shorter than PKT_LEN. Code 2'b11 never ends a packet.
- R11: A packet also ends once PKT_LEN flits of it have moved (PKT_LEN defaults to 5), even if no tail flit was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N | Per-channel request: a flit is waiting at the head |
| gt_i | input | N | Per-channel class bit, sampled with a header flit (1 = GT) |
| ftype_i | input | 2*N | Per-channel flit type, channel c in bits [2c+1:2c] |
| blocked_i | input | 1 | The granted packet cannot advance this cycle |
| grant_o | output | N | One-hot grant |
| gidx_o | output | $clog2(N) | Index of the granted channel |
| gvalid_o | output | 1 | A grant is present |

## Verification
A round-robin pointer that is left in the wrong place shows up at the very next arbitration: the grant goes to a channel other than the one after the last completed packet. This is why the test sequences always keep two requests of the same class competing. A lock that is dropped or held wrongly shows within one cycle of the flit that should end or continue the packet. That flit is a tail, a count limit, a reserved data code or a stall. In those cases the grant either jumps early to a waiting GT request or stays on a finished channel. A class bit latched wrongly stays hidden until the stalled channel has to compete again.

// File: rtl/gtbe_pkg.sv
package gtbe_pkg;

    // Flit type codes carried beside each channel's head flit
    typedef enum logic [1:0] {
        FT_DATA = 2'b00,
        FT_HEAD = 2'b01,
        FT_TAIL = 2'b10,
        FT_RSVD = 2'b11
    } flit_e;

endpackage

// File: rtl/gtbe_class_mask.sv
module gtbe_class_mask
    import gtbe_pkg::*;
#(
    parameter int N = 4,
    parameter int K = 2
) (
    input  logic [N-1:0]   req_i,
    input  logic [N-1:0]   gt_i,
    input  logic [2*N-1:0] ftype_i,
    input  logic [N-1:0]   cls_q,
    output logic [N-1:0]   gt_elig,
    output logic [N-1:0]   be_elig
);

    for (genvar g = 0; g < N; g++) begin : g_chan
        logic is_head;
        logic eff_gt;
        assign is_head = (ftype_i[2*g +: 2] == FT_HEAD);
        // a header carries its own class; a mid-packet flit uses the latched one
        assign eff_gt  = is_head ? gt_i[g] : cls_q[g];
        assign gt_elig[g] = req_i[g] & eff_gt;
        if (g < K) begin : g_resv
            assign be_elig[g] = 1'b0;
        end else begin : g_open
            assign be_elig[g] = req_i[g] & ~eff_gt;
        end
    end

endmodule

// File: rtl/gtbe_rr_pick.sv
module gtbe_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int off = 0; off < N; off++) begin
            int cand;
            cand = (int'(ptr) + off) % N;
            if (!any && req[cand]) begin
                any = 1'b1;
                idx = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/gtbe_vc_sched.sv
module gtbe_vc_sched
    import gtbe_pkg::*;
#(
    parameter int N       = 4,
    parameter int K       = 2,
    parameter int PKT_LEN = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [N-1:0]                        req_i,
    input  logic [N-1:0]                        gt_i,
    input  logic [2*N-1:0]                      ftype_i,
    input  logic                                blocked_i,
    output logic [N-1:0]                        grant_o,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] gidx_o,
    output logic                                gvalid_o
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(PKT_LEN + 1);

    typedef struct packed {
        logic                   lock;
        logic [IW-1:0]          owner;
        logic [IW-1:0]          ptr_gt;
        logic [IW-1:0]          ptr_be;
        logic [N-1:0]           cls;
        logic [N-1:0][CW-1:0]   cnt;
    } st_t;

    st_t st_q, st_d;

    logic [N-1:0]  gt_elig, be_elig;
    logic [IW-1:0] gt_idx, be_idx;
    logic          gt_any, be_any;
    logic          lock_w;

    assign lock_w = st_q.lock;

    gtbe_class_mask #(.N(N), .K(K)) u_mask (
        .req_i   (req_i),
        .gt_i    (gt_i),
        .ftype_i (ftype_i),
        .cls_q   (st_q.cls),
        .gt_elig (gt_elig),
        .be_elig (be_elig)
    );

    gtbe_rr_pick #(.N(N), .IW(IW)) u_pick_gt (
        .req (gt_elig),
        .ptr (st_q.ptr_gt),
        .idx (gt_idx),
        .any (gt_any)
    );

    gtbe_rr_pick #(.N(N), .IW(IW)) u_pick_be (
        .req (be_elig),
        .ptr (st_q.ptr_be),
        .idx (be_idx),
        .any (be_any)
    );

    function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] g);
        return (int'(g) == N - 1) ? '0 : IW'(int'(g) + 1);
    endfunction

    logic [IW-1:0] sel;
    logic          sel_v;
    logic          xfer;
    logic [1:0]    ft;
    logic          head;
    logic          done;
    logic          cls_new;
    logic [CW-1:0] cnt_new;

    always_comb begin
        st_d = st_q;

        // grant selection: a held packet first, then GT class, then BE class
        if (st_q.lock) begin
            sel   = st_q.owner;
            sel_v = 1'b1;
        end else if (gt_any) begin
            sel   = gt_idx;
            sel_v = 1'b1;
        end else if (be_any) begin
            sel   = be_idx;
            sel_v = be_any;
        end else begin
            sel   = '0;
            sel_v = 1'b0;
        end

        ft      = ftype_i[2*int'(sel) +: 2];
        head    = (ft == FT_HEAD);
        xfer    = sel_v && req_i[sel] && !blocked_i;
        cnt_new = head ? CW'(1) : st_q.cnt[sel] + CW'(1);
        cls_new = head ? gt_i[sel] : st_q.cls[sel];
        done    = (!head && ft == FT_TAIL) || (cnt_new == CW'(PKT_LEN));

        if (sel_v && blocked_i) begin
            st_d.lock = 1'b0;
        end

        if (xfer) begin
            st_d.cls[sel] = cls_new;
            if (done) begin
                st_d.lock     = 1'b0;
                st_d.cnt[sel] = '0;
                if (cls_new) begin
                    st_d.ptr_gt = step_idx(sel);
                end else begin
                    st_d.ptr_be = step_idx(sel);
                end
            end else begin
                st_d.lock     = 1'b1;
                st_d.owner    = sel;
                st_d.cnt[sel] = cnt_new;
            end
        end

        for (int i = 0; i < N; i++) begin
            grant_o[i] = sel_v && (sel == IW'(i));
        end
        gidx_o   = sel;
        gvalid_o = sel_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gtbe_vc_sched_chk.sv
module gtbe_vc_sched_chk
    import gtbe_pkg::*;
#(
    parameter int N       = 4,
    parameter int K       = 2,
    parameter int PKT_LEN = 5,
    parameter int IW      = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   req_i,
    input logic [N-1:0]   gt_i,
    input logic [2*N-1:0] ftype_i,
    input logic           blocked_i,
    input logic [N-1:0]   grant_o,
    input logic [IW-1:0]  gidx_o,
    input logic           gvalid_o,
    input logic           lock_w,
    input logic [N-1:0]   gt_elig
);

    logic [1:0] cur_ft;
    assign cur_ft = ftype_i[2*int'(gidx_o) +: 2];

    // R2
    onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R2
    idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gvalid_o |-> grant_o[gidx_o]);

    // R3
    gt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_w && |gt_elig) |-> (gvalid_o && gt_elig[gidx_o]));

    // R6
    no_be_on_gt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gvalid_o && int'(gidx_o) < K && cur_ft == FT_HEAD) |-> gt_i[gidx_o]);

    // R9
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gvalid_o && blocked_i) |=> !lock_w);

    if (PKT_LEN > 1) begin : g_hold
        // R8
        hold_after_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gvalid_o && req_i[gidx_o] && !blocked_i && cur_ft == FT_HEAD)
            |=> (gvalid_o && gidx_o == $past(gidx_o)));
    end

endmodule

bind gtbe_vc_sched gtbe_vc_sched_chk #(
    .N(N), .K(K), .PKT_LEN(PKT_LEN), .IW(IW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .gt_i      (gt_i),
    .ftype_i   (ftype_i),
    .blocked_i (blocked_i),
    .grant_o   (grant_o),
    .gidx_o    (gidx_o),
    .gvalid_o  (gvalid_o),
    .lock_w    (lock_w),
    .gt_elig   (gt_elig)
);

// File: tb/tb_gtbe_vc_sched.sv
module tb_gtbe_vc_sched;

    localparam int N  = 4;
    localparam int K  = 2;
    localparam int PL = 5;
    localparam int IW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req_i = '0;
    logic [N-1:0]   gt_i = '0;
    logic [2*N-1:0] ftype_i = '0;
    logic           blocked_i = 1'b0;
    logic [N-1:0]   grant_o;
    logic [IW-1:0]  gidx_o;
    logic           gvalid_o;

    always #10 clk = ~clk;

    gtbe_vc_sched #(.N(N), .K(K), .PKT_LEN(PL)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .gt_i      (gt_i),
        .ftype_i   (ftype_i),
        .blocked_i (blocked_i),
        .grant_o   (grant_o),
        .gidx_o    (gidx_o),
        .gvalid_o  (gvalid_o)
    );

    typedef struct {
        logic  v;
        int    idx;
        string tag;
    } exp_t;

    exp_t sb[$];
    exp_t mon_e;
    int   n_chk = 0;
    int   n_bad = 0;
    int   pos[N];
    int   plen[N];
    bit   finished = 0;

    // Flit type codes from R10: 01 header, 10 tail, 00 and 11 data
    function automatic logic [1:0] ft_of(int p, int l);
        if (p == 0)     return 2'b01;
        if (p == l - 1) return 2'b10;
        if (p % 2 == 1) return 2'b00;
        return 2'b11;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected grant
    task automatic cyc(input logic [N-1:0] rq, input logic [N-1:0] gv,
                       input logic blk, input logic ev, input int ei,
                       input string tag, input int n = 1);
        for (int r = 0; r < n; r++) begin
            @(posedge clk); #1;
            req_i     = rq;
            gt_i      = gv;
            blocked_i = blk;
            for (int c = 0; c < N; c++) ftype_i[2*c +: 2] = ft_of(pos[c], plen[c]);
            sb.push_back('{ev, ei, tag});
            if (ev && !blk && rq[ei]) pos[ei] = (pos[ei] + 1) % plen[ei];
        end
    endtask

    // Monitor: compares at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            logic [N-1:0] eg;
            mon_e = sb.pop_front();
            eg = mon_e.v ? (N'(1) << mon_e.idx) : '0;
            n_chk++;
            if (gvalid_o !== mon_e.v || grant_o !== eg ||
                (mon_e.v && int'(gidx_o) != mon_e.idx)) begin
                n_bad++;
                $display("FAIL %s: valid=%0d idx=%0d grant=%b expected valid=%0d idx=%0d grant=%b",
                         mon_e.tag, gvalid_o, gidx_o, grant_o, mon_e.v, mon_e.idx, eg);
            end
        end
    end

    initial begin
        for (int c = 0; c < N; c++) begin pos[c] = 0; plen[c] = PL; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle after reset
        cyc(4'b0000, 4'b0000, 0, 0, 0, "R1", 2);
        // R4: BE round robin, pointer starts at 0
        cyc(4'b1100, 4'b0000, 0, 1, 2, "R4", 5);
        cyc(4'b1100, 4'b0000, 0, 1, 3, "R4", 5);
        cyc(4'b1100, 4'b0000, 0, 1, 2, "R4", 5);
        // R3: GT on ch0 beats waiting BE on ch3
        cyc(4'b1001, 4'b0001, 0, 1, 0, "R3", 5);
        cyc(4'b1000, 4'b0000, 0, 1, 3, "R4", 5);
        // R6: BE header on a reserved channel is ignored
        cyc(4'b0001, 4'b0000, 0, 0, 0, "R6", 2);
        // R7: spilled GT on ch3 beats BE on ch2
        cyc(4'b1100, 4'b1000, 0, 1, 3, "R7", 5);
        cyc(4'b0100, 4'b0000, 0, 1, 2, "R7", 5);
        // R5: GT round robin with wrap through BE indices
        cyc(4'b0011, 4'b0011, 0, 1, 0, "R5", 5);
        cyc(4'b0011, 4'b0011, 0, 1, 1, "R5", 5);
        cyc(4'b0011, 4'b0011, 0, 1, 0, "R5", 5);
        // R8: locked BE packet is not preempted by arriving GT
        cyc(4'b0100, 4'b0000, 0, 1, 2, "R8", 1);
        cyc(4'b0101, 4'b0001, 0, 1, 2, "R8", 4);
        cyc(4'b0001, 4'b0001, 0, 1, 0, "R8", 5);
        // R9: stall releases the lock, GT takes over, stalled packet resumes
        cyc(4'b1000, 4'b0000, 0, 1, 3, "R9", 1);
        cyc(4'b1001, 4'b0001, 1, 1, 3, "R9", 1);
        cyc(4'b1001, 4'b0001, 0, 1, 0, "R9", 5);
        cyc(4'b1000, 4'b1000, 0, 1, 3, "R9", 4);
        // R10: three-flit packet ends on tail, then ch3 is served
        plen[2] = 3;
        cyc(4'b1100, 4'b0000, 0, 1, 2, "R10", 3);
        cyc(4'b1100, 4'b0000, 0, 1, 3, "R10", 5);
        plen[2] = PL;
        // R11: packet without tail still ends after PL flits
        plen[3] = 8;
        cyc(4'b1000, 4'b0000, 0, 1, 3, "R11", 1);
        cyc(4'b1100, 4'b0000, 0, 1, 3, "R11", 4);
        pos[3] = 0; plen[3] = PL;
        cyc(4'b0100, 4'b0000, 0, 1, 2, "R11", 5);
        // R1: idle again
        cyc(4'b0000, 4'b0000, 0, 0, 0, "R1", 1);

        while (sb.size() > 0) @(negedge clk);
        #2;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule